// File: doc/BRIEF.md
# Link Equalization Phase Sequencer

This block steps one link through the four transmitter equalization phases. It handles a single port, set up by a role input as either the downstream or the upstream end. The receive path supplies one event per decoded training set. Each event gives the set type (TS0 or TS1), the 2-bit equalization control (EC) code, the retimer-extend bit and a valid strobe. The receiver-tuning logic supplies a one-cycle "BER target met" pulse.

From these inputs the block decides which EC code and which set type the transmitter sends. It also reports the current phase and, at the end, a completion flag and a phase-3-success flag. Advancing on received sets needs two qualifying sets in a row. Advancing on the local receiver needs a BER pulse in the phase that waits for one.

The phases use the NRZ-like TS0 set while the link is still weak and switch to TS1 later. The point of the switch depends on the role. A start pulse begins a run from idle or from the finished state.

Top module: `eq_phase_seq`

## Requirements
- R1: After reset, active_o, done_o and p3_ok_o are 0, phase_o is 0, and the transmit request is TS1 (tx_is_ts1_o=1) with EC 00b.
- R2: A start_i pulse while inactive makes active_o 1 and clears done_o and p3_ok_o. The downstream role (is_dsp_i=1) enters phase 1 and the upstream role enters phase 0. A start_i pulse while active has no effect.
- R3: While active, tx_ec_o equals the phase number: 00b, 01b, 10b or 11b for phases 0 to 3. When not active it is 00b.
- R4: While active, tx_is_ts1_o (1=TS1, 0=TS0) is 1 only in phases 2 and 3 for the downstream role, and only in phase 3 for the upstream role.
- R5: The upstream role leaves phase 0 for phase 1 after two consecutive valid sets with EC=01b. A TS1 always qualifies. A TS0 qualifies only when rx_rt_ext_i is 0.
- R6: The upstream role leaves phase 1 for phase 2 after two consecutive valid TS1 sets with EC=10b. A TS0 does not qualify.
- R7: The upstream role leaves phase 2 for phase 3 on a ber_met_i pulse.
- R8: The upstream role finishes phase 3 after two consecutive valid TS1 sets with EC=00b.
- R9: The downstream role leaves phase 1 for phase 2 on a ber_met_i pulse. It leaves phase 2 for phase 3 after two consecutive valid sets of either type with EC=11b.
- R10: The downstream role finishes phase 3 on a ber_met_i pulse. On finishing, in either role, active_o falls and done_o and p3_ok_o become 1. phase_o stays 3 and the transmit request is TS1 with EC 00b.
- R11: A valid set that does not qualify in the current phase resets the consecutive count. Cycles with rx_valid_i low neither count nor break the run.
- R12: ber_met_i has no effect in a phase that waits on received sets. Valid sets have no effect in a phase that waits on ber_met_i.
- R13: The finished state holds until the next start_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_dsp_i | input | 1 | Role: 1 downstream, 0 upstream; static during a run |
| start_i | input | 1 | Begins a run |
| rx_valid_i | input | 1 | A received training set is present this cycle |
| rx_is_ts1_i | input | 1 | Received set type: 1 TS1, 0 TS0 |
| rx_ec_i | input | 2 | Received EC code |
| rx_rt_ext_i | input | 1 | Received retimer-extend bit |
| ber_met_i | input | 1 | Local receiver reached its BER target |
| tx_is_ts1_o | output | 1 | Set type to transmit: 1 TS1, 0 TS0 |
| tx_ec_o | output | 2 | EC code to transmit |
| phase_o | output | 2 | Current phase |
| active_o | output | 1 | Run in progress |
| done_o | output | 1 | Equalization complete |
| p3_ok_o | output | 1 | Phase 3 successful |

## Verification
Every result is due one clock after its cause. A start pulse, the second qualifying set of a pair or a BER pulse is taken at a rising edge, and the phase, transmit request and flags then change at that edge. The first set of a pair, a disqualified set or an ignored pulse leaves all outputs unchanged at that edge. The bench drives each stimulus for exactly one cycle from a falling edge. It samples every output at the next falling edge, which is half a period after the edge that must have applied the stimulus. Because of this, a late or early transition shows up as a wrong value in the row where it occurs.

// File: rtl/eqseq_pkg.sv
package eqseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PH0,
    ST_PH1,
    ST_PH2,
    ST_PH3,
    ST_DONE
  } eq_state_e;

  localparam logic [1:0] EC_P0 = 2'b00;
  localparam logic [1:0] EC_P1 = 2'b01;
  localparam logic [1:0] EC_P2 = 2'b10;
  localparam logic [1:0] EC_P3 = 2'b11;
endpackage

// File: rtl/eq_rx_qual.sv
module eq_rx_qual
  import eqseq_pkg::*;
(
  input  eq_state_e  state_i,
  input  logic       is_dsp_i,
  input  logic       rx_is_ts1_i,
  input  logic [1:0] rx_ec_i,
  input  logic       rx_rt_ext_i,
  output logic       want_pair_o,
  output logic       match_o
);
  always_comb begin
    want_pair_o = 1'b0;
    match_o     = 1'b0;
    if (is_dsp_i) begin
      if (state_i == ST_PH2) begin
        want_pair_o = 1'b1;
        match_o     = (rx_ec_i == EC_P3);
      end
    end else begin
      unique case (state_i)
        ST_PH0: begin
          want_pair_o = 1'b1;
          match_o     = (rx_ec_i == EC_P1) && (rx_is_ts1_i || !rx_rt_ext_i);
        end
        ST_PH1: begin
          want_pair_o = 1'b1;
          match_o     = rx_is_ts1_i && (rx_ec_i == EC_P2);
        end
        ST_PH3: begin
          want_pair_o = 1'b1;
          match_o     = rx_is_ts1_i && (rx_ec_i == EC_P0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eq_pair_cnt.sv
module eq_pair_cnt #(
  parameter int unsigned PAIR_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic match_i,
  output logic hit_o
);
  localparam int unsigned CW = (PAIR_LEN < 2) ? 1 : $clog2(PAIR_LEN);
  localparam logic [CW-1:0] LAST = CW'(PAIR_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = valid_i && match_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || hit_o) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      cnt_q <= match_i ? cnt_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/eq_phase_fsm.sv
module eq_phase_fsm
  import eqseq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      is_dsp_i,
  input  logic      start_i,
  input  logic      pair_hit_i,
  input  logic      ber_met_i,
  output eq_state_e state_o,
  output logic      adv_o,
  output logic      done_o,
  output logic      p3_ok_o
);
  eq_state_e state_q, state_d;
  logic      done_q, p3_ok_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = is_dsp_i ? ST_PH1 : ST_PH0;
      ST_PH0:           if (pair_hit_i) state_d = ST_PH1;
      ST_PH1: begin
        if (is_dsp_i) begin
          if (ber_met_i) state_d = ST_PH2;
        end else if (pair_hit_i) begin
          state_d = ST_PH2;
        end
      end
      ST_PH2: begin
        if (is_dsp_i) begin
          if (pair_hit_i) state_d = ST_PH3;
        end else if (ber_met_i) begin
          state_d = ST_PH3;
        end
      end
      ST_PH3: begin
        if (is_dsp_i) begin
          if (ber_met_i) state_d = ST_DONE;
        end else if (pair_hit_i) begin
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      p3_ok_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_DONE && state_q == ST_PH3) begin
        done_q  <= 1'b1;
        p3_ok_q <= 1'b1;
      end else if (state_q != ST_DONE && state_q != ST_IDLE) begin
        done_q  <= done_q;
        p3_ok_q <= p3_ok_q;
      end else if (start_i) begin
        done_q  <= 1'b0;
        p3_ok_q <= 1'b0;
      end
    end
  end

  assign state_o = state_q;
  assign adv_o   = (state_d != state_q);
  assign done_o  = done_q;
  assign p3_ok_o = p3_ok_q;
endmodule

// File: rtl/eq_tx_map.sv
module eq_tx_map
  import eqseq_pkg::*;
(
  input  eq_state_e  state_i,
  input  logic       is_dsp_i,
  output logic       tx_is_ts1_o,
  output logic [1:0] tx_ec_o,
  output logic [1:0] phase_o,
  output logic       active_o
);
  always_comb begin
    tx_is_ts1_o = 1'b1;
    tx_ec_o     = EC_P0;
    phase_o     = 2'd0;
    active_o    = 1'b1;
    unique case (state_i)
      ST_PH0: begin
        tx_is_ts1_o = 1'b0;
        tx_ec_o     = EC_P0;
      end
      ST_PH1: begin
        tx_is_ts1_o = 1'b0;
        tx_ec_o     = EC_P1;
        phase_o     = 2'd1;
      end
      ST_PH2: begin
        tx_is_ts1_o = is_dsp_i;
        tx_ec_o     = EC_P2;
        phase_o     = 2'd2;
      end
      ST_PH3: begin
        tx_ec_o = EC_P3;
        phase_o = 2'd3;
      end
      ST_DONE: begin
        phase_o  = 2'd3;
        active_o = 1'b0;
      end
      default: active_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq
  import eqseq_pkg::*;
#(
  parameter int unsigned PAIR_LEN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       is_dsp_i,
  input  logic       start_i,
  input  logic       rx_valid_i,
  input  logic       rx_is_ts1_i,
  input  logic [1:0] rx_ec_i,
  input  logic       rx_rt_ext_i,
  input  logic       ber_met_i,
  output logic       tx_is_ts1_o,
  output logic [1:0] tx_ec_o,
  output logic [1:0] phase_o,
  output logic       active_o,
  output logic       done_o,
  output logic       p3_ok_o
);
  eq_state_e state;
  logic      want_pair, match, pair_hit, adv;

  eq_rx_qual u_qual (
    .state_i     (state),
    .is_dsp_i    (is_dsp_i),
    .rx_is_ts1_i (rx_is_ts1_i),
    .rx_ec_i     (rx_ec_i),
    .rx_rt_ext_i (rx_rt_ext_i),
    .want_pair_o (want_pair),
    .match_o     (match)
  );

  eq_pair_cnt #(.PAIR_LEN(PAIR_LEN)) u_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (adv),
    .valid_i (rx_valid_i && want_pair),
    .match_i (match),
    .hit_o   (pair_hit)
  );

  eq_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .is_dsp_i   (is_dsp_i),
    .start_i    (start_i),
    .pair_hit_i (pair_hit),
    .ber_met_i  (ber_met_i),
    .state_o    (state),
    .adv_o      (adv),
    .done_o     (done_o),
    .p3_ok_o    (p3_ok_o)
  );

  eq_tx_map u_map (
    .state_i     (state),
    .is_dsp_i    (is_dsp_i),
    .tx_is_ts1_o (tx_is_ts1_o),
    .tx_ec_o     (tx_ec_o),
    .phase_o     (phase_o),
    .active_o    (active_o)
  );
endmodule

// File: rtl/eq_phase_seq_chk.sv
module eq_phase_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       is_dsp_i,
  input logic       start_i,
  input logic       rx_valid_i,
  input logic       rx_is_ts1_i,
  input logic [1:0] rx_ec_i,
  input logic       rx_rt_ext_i,
  input logic       ber_met_i,
  input logic       tx_is_ts1_o,
  input logic [1:0] tx_ec_o,
  input logic [1:0] phase_o,
  input logic       active_o,
  input logic       done_o,
  input logic       p3_ok_o
);
  // R3
  ec_tracks_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> tx_ec_o == phase_o);

  // R4
  ts1_in_ph3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && phase_o == 2'd3) |-> tx_is_ts1_o);

  // R2
  dsp_no_ph0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && is_dsp_i) |-> phase_o != 2'd0);

  // R11
  phase_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> phase_o >= $past(phase_o));

  // R5
  usp_ph1_needs_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_dsp_i && active_o && $past(active_o) && phase_o == 2'd1 && $past(phase_o) == 2'd0)
      |-> $past(rx_valid_i));

  // R10
  done_from_ph3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(phase_o) == 2'd3 && $past(active_o) && p3_ok_o && !active_o));

  // R10
  done_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_is_ts1_o && tx_ec_o == 2'b00));
endmodule

bind eq_phase_seq eq_phase_seq_chk u_chk (.*);

// File: tb/eq_phase_seq_bench.sv
module eq_phase_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_dsp = 1'b0, start = 1'b0, rx_valid = 1'b0, rx_ts1 = 1'b0, rx_rtx = 1'b0, ber = 1'b0;
  logic [1:0] rx_ec = 2'b00;
  logic       tx_ts1, active, done, p3_ok;
  logic [1:0] tx_ec, phase;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  eq_phase_seq u_eq_phase_seq (
    .clk_i(clk), .rst_ni(rst_n), .is_dsp_i(is_dsp), .start_i(start),
    .rx_valid_i(rx_valid), .rx_is_ts1_i(rx_ts1), .rx_ec_i(rx_ec), .rx_rt_ext_i(rx_rtx),
    .ber_met_i(ber), .tx_is_ts1_o(tx_ts1), .tx_ec_o(tx_ec), .phase_o(phase),
    .active_o(active), .done_o(done), .p3_ok_o(p3_ok)
  );

  // op: 0 start, 1 rx set, 2 ber pulse, 3 quiet
  // {op[1:0], dsp, ts1, ec[1:0], rtx, phase[1:0], active, done}
  localparam int NV = 27;
  localparam logic [10:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,2'b00,1'b0,2'd0,1'b1,1'b0}, // R2 usp start
    {2'd1,1'b0,1'b0,2'b01,1'b1,2'd0,1'b1,1'b0}, // R5 TS0 with extend
    {2'd1,1'b0,1'b0,2'b01,1'b0,2'd0,1'b1,1'b0}, // R5 first
    {2'd2,1'b0,1'b0,2'b00,1'b0,2'd0,1'b1,1'b0}, // R12 ber ignored
    {2'd1,1'b0,1'b1,2'b01,1'b0,2'd1,1'b1,1'b0}, // R5 R11 second
    {2'd1,1'b0,1'b1,2'b10,1'b0,2'd1,1'b1,1'b0}, // R6 first
    {2'd1,1'b0,1'b0,2'b10,1'b0,2'd1,1'b1,1'b0}, // R6 R11 TS0 breaks
    {2'd1,1'b0,1'b1,2'b10,1'b0,2'd1,1'b1,1'b0}, // R6
    {2'd1,1'b0,1'b1,2'b10,1'b0,2'd2,1'b1,1'b0}, // R6
    {2'd1,1'b0,1'b1,2'b11,1'b0,2'd2,1'b1,1'b0}, // R12 set ignored
    {2'd2,1'b0,1'b0,2'b00,1'b0,2'd3,1'b1,1'b0}, // R7
    {2'd1,1'b0,1'b1,2'b00,1'b0,2'd3,1'b1,1'b0}, // R8 first
    {2'd1,1'b0,1'b1,2'b11,1'b0,2'd3,1'b1,1'b0}, // R8 R11 break
    {2'd1,1'b0,1'b1,2'b00,1'b0,2'd3,1'b1,1'b0}, // R8
    {2'd3,1'b0,1'b0,2'b00,1'b0,2'd3,1'b1,1'b0}, // R11 gap
    {2'd1,1'b0,1'b1,2'b00,1'b0,2'd3,1'b0,1'b1}, // R8 R10 done
    {2'd3,1'b0,1'b0,2'b00,1'b0,2'd3,1'b0,1'b1}, // R13 hold
    {2'd0,1'b1,1'b0,2'b00,1'b0,2'd1,1'b1,1'b0}, // R2 R13 dsp restart
    {2'd1,1'b1,1'b0,2'b10,1'b0,2'd1,1'b1,1'b0}, // R12 set ignored
    {2'd2,1'b1,1'b0,2'b00,1'b0,2'd2,1'b1,1'b0}, // R9 ber
    {2'd2,1'b1,1'b0,2'b00,1'b0,2'd2,1'b1,1'b0}, // R12 ber ignored
    {2'd1,1'b1,1'b0,2'b11,1'b0,2'd2,1'b1,1'b0}, // R9 first
    {2'd1,1'b1,1'b1,2'b10,1'b0,2'd2,1'b1,1'b0}, // R11 break
    {2'd1,1'b1,1'b1,2'b11,1'b0,2'd2,1'b1,1'b0}, // R9
    {2'd1,1'b1,1'b0,2'b11,1'b0,2'd3,1'b1,1'b0}, // R9 mixed types
    {2'd1,1'b1,1'b1,2'b00,1'b0,2'd3,1'b1,1'b0}, // R12 set ignored
    {2'd2,1'b1,1'b0,2'b00,1'b0,2'd3,1'b0,1'b1}  // R10 dsp done
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic dsp, input logic [1:0] ph,
                         input logic act, input logic dn);
    logic exp_ts1;
    exp_ts1 = !act ? 1'b1 : (dsp ? (ph >= 2'd2) : (ph == 2'd3));
    chk({tag, " phase"}, phase, ph);
    chk({tag, " active"}, active, act);
    chk({tag, " done"}, done, dn);
    chk({tag, " p3_ok"}, p3_ok, dn);
    chk({tag, " tx_ec R3"}, tx_ec, act ? ph : 2'b00);
    chk({tag, " tx_ts1 R4"}, tx_ts1, exp_ts1);
  endtask

  task automatic step(input logic [1:0] op, input logic dsp, input logic ts1,
                      input logic [1:0] ec, input logic rtx);
    is_dsp   = dsp;
    start    = (op == 2'd0);
    rx_valid = (op == 2'd1);
    ber      = (op == 2'd2);
    rx_ts1   = ts1;
    rx_ec    = ec;
    rx_rtx   = rtx;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; rx_valid = 1'b0; ber = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 1'b0, 2'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", 1'b0, 2'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      step(v[10:9], v[8], v[7], v[6:5], v[4]);
      chk_all($sformatf("vec %0d", i), v[8], v[3:2], v[1], v[0]);
    end

    // R2 start while active is ignored
    step(2'd3, 1'b0, 1'b0, 2'b00, 1'b0);
    step(2'd0, 1'b0, 1'b0, 2'b00, 1'b0);
    chk_all("R2 usp start", 1'b0, 2'd0, 1'b1, 1'b0);
    step(2'd1, 1'b0, 1'b1, 2'b01, 1'b0);
    step(2'd1, 1'b0, 1'b1, 2'b01, 1'b0);
    chk_all("R5 usp to ph1", 1'b0, 2'd1, 1'b1, 1'b0);
    step(2'd0, 1'b0, 1'b0, 2'b00, 1'b0);
    chk_all("R2 start ignored", 1'b0, 2'd1, 1'b1, 1'b0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 reset mid-run", 1'b0, 2'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step(2'd3, 1'b0, 1'b0, 2'b00, 1'b0);
    chk_all("R1 idle holds", 1'b0, 2'd0, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule